// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the slave side of a converter's serial readout. It keeps the most recent finished conversion word and, when a host pulls the active-low select line, drives that word out on a serial data pin, most significant bit first. Each new bit appears on a falling edge of the host's serial clock. The block runs entirely on the converter master clock. Select and serial clock are asynchronous to it, so each passes through a two-flop synchronizer, and edges are found by comparing each synchronized value with its value one cycle earlier.

An active-low ready flag tells the host that a word is waiting. A select edge is honoured only while that flag is low. After acceptance, a rising serial-clock edge arms the shifter before any falling edge may advance it. If the host deselects partway through a word, the bit on the pin is held until its period ends, and then the pin floats. A word that arrives during a read is parked and does not disturb the word being shifted. The output enable is a separate port, so the high-impedance state can be observed directly.

Top module: `sout_port`

## Requirements
- R1: Out of reset `rdyN` is 1 and `sdoEn` is 0.
- R2: A falling edge on `csN` while `rdyN` is 0 sets `sdoEn` to 1 within 4 clock cycles, with `sdo` equal to bit 15 (the MSB) of the held word.
- R3: A falling edge on `csN` while `rdyN` is 1 is ignored. A `csN` held low while a word arrives is not accepted until `csN` goes high and then low again.
- R4: After acceptance, a falling `sclk` edge that comes before the first rising `sclk` edge does not change `sdo`.
- R5: Once armed, each falling `sclk` edge presents the next lower bit on `sdo`, so that bit 15 is sent first and bit 0 last. `sdo` changes only on falling `sclk` edges.
- R6: The falling `sclk` edge that ends bit 0 sets `sdoEn` to 0. If no newer word is waiting, it also sets `rdyN` to 1.
- R7: If `csN` goes high during a bit, `sdoEn` and `sdo` hold until the next falling `sclk` edge, and then `sdoEn` goes to 0. If `csN` goes high before the shifter is armed, `sdoEn` goes to 0 at once. In both cases `rdyN` stays 0, and the next read starts again from bit 15.
- R8: A word loaded during a read does not alter the bits being sent. After that read, `rdyN` stays 0, and the next read returns the newer word.
- R9: If a load falls in the same cycle as the falling edge that completes a read, the loaded word is kept and `rdyN` stays 0.
- R10: A load while idle replaces an unread word, and the newest word is the one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter master clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loadValid | input | 1 | Strobe: a finished conversion word is on loadWord |
| loadWord | input | 16 | Conversion word to present |
| csN | input | 1 | Host chip select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| rdyN | output | 1 | Active-low word-ready flag |
| sdo | output | 1 | Serial data bit (0 while floated) |
| sdoEn | output | 1 | Output enable for the serial data pin |

## Verification
The risky collision is a new conversion word arriving in the same master-clock cycle in which the synchronized falling edge retires the last bit. In that cycle, completion wants to raise the ready flag while the load wants to lower it. The bench counts the synchronizer stages after the final serial-clock drop and strobes the load exactly in the cycle the edge is acted on. It then requires `rdyN` to stay low and the following read to return the new word. A second pairing is a load placed in the middle of a read, which must leave the bits already in flight unchanged.

// File: rtl/sout_pkg.sv
package sout_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_SHIFT,
    ST_FLUSH
  } portState_t;

  typedef struct packed {
    logic take;    // load shifter from held word, enable output
    logic shift;   // advance to next bit
    logic finish;  // last bit period ended, word consumed
    logic drop;    // read abandoned, output floats
    logic busy;    // a word is in flight
  } dpStrobe_t;

endpackage

// File: rtl/sout_sync.sv
module sout_sync #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= RESET_VAL;
          else       chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= RESET_VAL;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sout_ctrl.sv
module sout_ctrl
  import sout_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csS,
  input  logic      sclkS,
  input  logic      wordReady,
  output dpStrobe_t stb
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  portState_t state, stateNext;
  logic [CNT_W-1:0] bitCnt;
  logic csPrev, sclkPrev;
  logic csFall, sclkRise, sclkFall;

  assign csFall   = csPrev & ~csS;
  assign sclkRise = ~sclkPrev & sclkS;
  assign sclkFall = sclkPrev & ~sclkS;

  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (csFall && wordReady) begin
          stb.take  = 1'b1;
          stateNext = ST_ARM;
        end
      end
      ST_ARM: begin
        if (csS) begin
          stb.drop  = 1'b1;
          stateNext = ST_IDLE;
        end else if (sclkRise) begin
          stateNext = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (sclkFall) begin
          if (bitCnt == LAST_BIT) begin
            stb.finish = 1'b1;
            stateNext  = ST_IDLE;
          end else if (csS) begin
            stb.drop  = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            stb.shift = 1'b1;
          end
        end else if (csS) begin
          stateNext = ST_FLUSH;
        end
      end
      ST_FLUSH: begin
        if (sclkFall) begin
          if (bitCnt == LAST_BIT) stb.finish = 1'b1;
          else                    stb.drop   = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    stb.busy = (state != ST_IDLE) || stb.take;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      state    <= stateNext;
      csPrev   <= csS;
      sclkPrev <= sclkS;
      if (stb.take)       bitCnt <= '0;
      else if (stb.shift) bitCnt <= bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/sout_dpath.sv
module sout_dpath
  import sout_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              loadValid,
  input  logic [WORD_W-1:0] loadWord,
  output logic              wordReady,
  output logic              sdo,
  output logic              sdoEn
);
  logic [WORD_W-1:0] curWord, pendWord, shReg;
  logic curFull, pendFull, oe;
  logic retire;

  assign retire = stb.finish | stb.drop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curWord  <= '0;
      pendWord <= '0;
      curFull  <= 1'b0;
      pendFull <= 1'b0;
    end else if (retire) begin
      if (loadValid) begin
        curWord  <= loadWord;
        curFull  <= 1'b1;
        pendFull <= 1'b0;
      end else if (pendFull) begin
        curWord  <= pendWord;
        curFull  <= 1'b1;
        pendFull <= 1'b0;
      end else if (stb.finish) begin
        curFull <= 1'b0;
      end
    end else if (loadValid) begin
      if (stb.busy) begin
        pendWord <= loadWord;
        pendFull <= 1'b1;
      end else begin
        curWord <= loadWord;
        curFull <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      oe    <= 1'b0;
    end else begin
      if (stb.take)       shReg <= curWord;
      else if (stb.shift) shReg <= {shReg[WORD_W-2:0], 1'b0};
      if (stb.take)       oe <= 1'b1;
      else if (retire)    oe <= 1'b0;
    end
  end

  assign wordReady = curFull;
  assign sdoEn     = oe;
  assign sdo       = oe & shReg[WORD_W-1];
endmodule

// File: rtl/sout_port.sv
module sout_port
  import sout_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic [WORD_W-1:0] loadWord,
  input  logic              csN,
  input  logic              sclk,
  output logic              rdyN,
  output logic              sdo,
  output logic              sdoEn
);
  logic csS, sclkS, wordReady;
  dpStrobe_t stb;

  sout_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_csSync (
    .clk(clk), .rstN(rstN), .din(csN), .q(csS)
  );

  sout_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sclkSync (
    .clk(clk), .rstN(rstN), .din(sclk), .q(sclkS)
  );

  sout_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csS(csS), .sclkS(sclkS),
    .wordReady(wordReady), .stb(stb)
  );

  sout_dpath #(.WORD_W(WORD_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .loadValid(loadValid),
    .loadWord(loadWord), .wordReady(wordReady), .sdo(sdo), .sdoEn(sdoEn)
  );

  assign rdyN = ~wordReady;
endmodule

// File: rtl/sout_port_chk.sv
module sout_port_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic rdyN,
  input logic sdo,
  input logic sdoEn
);
  logic cs1, cs2, csP, sc1, sc2, scP;
  logic fallSeen, csFallSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cs1 <= 1'b1; cs2 <= 1'b1; csP <= 1'b1;
      sc1 <= 1'b0; sc2 <= 1'b0; scP <= 1'b0;
    end else begin
      cs1 <= csN;  cs2 <= cs1;  csP <= cs2;
      sc1 <= sclk; sc2 <= sc1;  scP <= sc2;
    end
  end

  assign fallSeen   = scP & ~sc2;
  assign csFallSeen = csP & ~cs2;

  AST_ACCEPT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoEn) |-> ($past(!rdyN) && $past(csFallSeen))); // R3

  AST_SDO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (sdoEn && $past(sdoEn) && (sdo != $past(sdo))) |-> $past(fallSeen)); // R5

  AST_FLOAT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdoEn) |-> $past(fallSeen || cs2)); // R7

  AST_READY_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdyN) |-> $fell(sdoEn)); // R6
endmodule

bind sout_port sout_port_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
  .rdyN(rdyN), .sdo(sdo), .sdoEn(sdoEn)
);

// File: tb/sout_port_tb.sv
module sout_port_tb;
  localparam int W = 16;
  localparam int HALF = 8;
  localparam int NVEC = 4;
  localparam logic [W-1:0] VECS [NVEC] = '{16'hA5C3, 16'h0001, 16'h8000, 16'hFFFF};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadValid = 1'b0;
  logic [W-1:0] loadWord = '0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic rdyN, sdo, sdoEn;
  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sout_port u_dut (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadWord(loadWord),
    .csN(csN), .sclk(sclk), .rdyN(rdyN), .sdo(sdo), .sdoEn(sdoEn)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic loadIt(input logic [W-1:0] w);
    loadValid = 1'b1;
    loadWord  = w;
    waitCyc(1);
    loadValid = 1'b0;
  endtask

  task automatic shiftBits(input int n, inout logic [W-1:0] acc);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1;
      waitCyc(HALF);
      acc = {acc[W-2:0], sdo};
      sclk = 1'b0;
      waitCyc(HALF);
    end
  endtask

  task automatic readWord(input string req, input logic [W-1:0] exp, input logic expRdyN);
    logic [W-1:0] acc = '0;
    csN = 1'b0;
    waitCyc(6);
    check({req, " enable after select (R2)"}, {31'd0, sdoEn}, 32'd1);
    check({req, " msb first (R2)"}, {31'd0, sdo}, {31'd0, exp[W-1]});
    shiftBits(W, acc);
    check({req, " word (R5)"}, {16'd0, acc}, {16'd0, exp});
    check({req, " float after last bit (R6)"}, {31'd0, sdoEn}, 32'd0);
    check({req, " ready after read (R6)"}, {31'd0, rdyN}, {31'd0, expRdyN});
    csN = 1'b1;
    waitCyc(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] acc;
    waitCyc(3);
    check("R1 ready flag at reset", {31'd0, rdyN}, 32'd1);
    check("R1 enable at reset", {31'd0, sdoEn}, 32'd0);
    rstN = 1'b1;
    waitCyc(3);

    // Vector table: each word is loaded, then read in full
    for (int v = 0; v < NVEC; v++) begin
      loadIt(VECS[v]);
      check("R10 ready after load", {31'd0, rdyN}, 32'd0);
      readWord("R5 vector", VECS[v], 1'b1);
    end

    // R3: select while not ready is ignored, held-low select not accepted
    csN = 1'b0;
    waitCyc(6);
    check("R3 select ignored when not ready", {31'd0, sdoEn}, 32'd0);
    loadIt(16'h1234);
    waitCyc(6);
    check("R3 held select not accepted", {31'd0, sdoEn}, 32'd0);
    csN = 1'b1;
    waitCyc(6);
    csN = 1'b0;
    waitCyc(6);
    check("R2 accepted after reselect", {31'd0, sdoEn}, 32'd1);
    // R7: deselect before arming floats at once
    csN = 1'b1;
    waitCyc(6);
    check("R7 float when deselected unarmed", {31'd0, sdoEn}, 32'd0);
    check("R7 ready kept", {31'd0, rdyN}, 32'd0);

    // R10: newer idle load replaces the unread word
    loadIt(16'h9000);

    // R4: falling edge before first rising edge does not shift
    sclk = 1'b1;
    waitCyc(HALF);
    csN = 1'b0;
    waitCyc(6);
    check("R4 msb shown", {31'd0, sdo}, 32'd1);
    sclk = 1'b0;
    waitCyc(HALF);
    check("R4 unarmed fall ignored", {31'd0, sdo}, 32'd1);
    sclk = 1'b1;
    waitCyc(HALF);
    check("R5 rise does not move data", {31'd0, sdo}, 32'd1);
    sclk = 1'b0;
    waitCyc(HALF);
    check("R5 next bit on fall", {31'd0, sdo}, 32'd0);
    // R7: mid-word deselect holds bit until the next fall
    sclk = 1'b1;
    waitCyc(HALF);
    csN = 1'b1;
    waitCyc(6);
    check("R7 enable held after deselect", {31'd0, sdoEn}, 32'd1);
    check("R7 bit held after deselect", {31'd0, sdo}, 32'd0);
    sclk = 1'b0;
    waitCyc(HALF);
    check("R7 float after bit period", {31'd0, sdoEn}, 32'd0);
    check("R7 ready kept after abort", {31'd0, rdyN}, 32'd0);
    readWord("R7 restart R10 newest", 16'h9000, 1'b1);

    // R8: load during a read is parked
    loadIt(16'h1111);
    csN = 1'b0;
    waitCyc(6);
    acc = '0;
    shiftBits(5, acc);
    loadIt(16'h4444);
    shiftBits(W - 5, acc);
    check("R8 word in flight intact", {16'd0, acc}, 32'h1111);
    check("R8 ready kept for parked word", {31'd0, rdyN}, 32'd0);
    csN = 1'b1;
    waitCyc(6);
    readWord("R8 parked word", 16'h4444, 1'b1);

    // R9: load in the same cycle as the completing fall
    loadIt(16'h2222);
    csN = 1'b0;
    waitCyc(6);
    acc = '0;
    shiftBits(W - 1, acc);
    sclk = 1'b1;
    waitCyc(HALF);
    acc = {acc[W-2:0], sdo};
    sclk = 1'b0;
    waitCyc(2);
    loadIt(16'h3333);
    waitCyc(6);
    check("R9 word completed", {16'd0, acc}, 32'h2222);
    check("R9 float at end", {31'd0, sdoEn}, 32'd0);
    check("R9 ready kept on collision", {31'd0, rdyN}, 32'd0);
    csN = 1'b1;
    waitCyc(6);
    readWord("R9 collided word", 16'h3333, 1'b1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule